// File: doc/BRIEF.md
# Reservation Station Array with Broadcast Tag Wakeup

This block holds issued operations in a small set of stations until both source operands are known. It then hands them, one per cycle, to a functional unit. At issue, each source is settled once. A source whose architectural register has no pending writer takes the register value. A source whose writer has already finished takes that writer's value. Any other source keeps the writer's reorder-buffer tag. A tag of zero always means the value is present. Each station also records the reorder-buffer tag that its own result will carry.

A result bus broadcasts a tag and a value. Every waiting source with that tag takes the value, and a station that has been dispatched is released when its own destination tag is broadcast. A dispatcher picks the lowest-numbered station whose operands are complete and presents its opcode, operands and destination tag on registered outputs. A flush input empties the whole array at once.

Top module: `rs_array`

## Requirements
- R1: `iss_ready` is high exactly when at least one station is free. An issue presented while `iss_ready` is low is ignored and dispatches nothing.
- R2: A source whose `*_busy` input is low captures `*_rf_val` with a zero tag, whatever `*_tag` holds.
- R3: A source whose `*_busy` is high and whose `*_prod_rdy` is high captures `*_prod_val` with a zero tag.
- R4: A source whose `*_busy` is high and whose `*_prod_rdy` is low records `*_tag`, and its station does not dispatch while the tag is nonzero.
- R5: A station whose two source tags are zero is dispatched. In the cycle after the selection edge, `disp_valid` is high and `disp_op`, `disp_a`, `disp_b` and `disp_dst` carry the stored opcode, first operand, second operand and destination tag. A station is dispatched only once.
- R6: When `bc_valid` is high, every waiting first or second source whose tag equals `bc_tag` takes `bc_val` and clears its tag.
- R7: A dispatched station becomes free on the edge where `bc_valid` is high and `bc_tag` equals its destination tag. The freed station can then be issued to again.
- R8: At most one station is dispatched per cycle. Among ready stations, the lowest index wins. Issue fills the lowest-numbered free station.
- R9: A broadcast in the same cycle as an issue, whose tag matches a source that would otherwise record that tag, is captured into the new station.
- R10: `flush` frees every station and clears `disp_valid` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all stations |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 4 | Opcode to store |
| iss_dst | input | 3 | Reorder-buffer tag of the result |
| a_busy | input | 1 | First source register has a pending writer |
| a_rf_val | input | 16 | First source register value |
| a_tag | input | 3 | First source producer tag |
| a_prod_rdy | input | 1 | First source producer has finished |
| a_prod_val | input | 16 | First source producer value |
| b_busy | input | 1 | Second source register has a pending writer |
| b_rf_val | input | 16 | Second source register value |
| b_tag | input | 3 | Second source producer tag |
| b_prod_rdy | input | 1 | Second source producer has finished |
| b_prod_val | input | 16 | Second source producer value |
| iss_ready | output | 1 | A station is free |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 3 | Broadcast result tag (nonzero) |
| bc_val | input | 16 | Broadcast result value |
| disp_valid | output | 1 | Dispatch valid (registered) |
| disp_op | output | 4 | Dispatched opcode |
| disp_dst | output | 3 | Dispatched destination tag |
| disp_a | output | 16 | Dispatched first operand |
| disp_b | output | 16 | Dispatched second operand |

## Verification
An issue or broadcast is presented for the edge after a falling edge. The station state it creates or wakes is selected on the following edge, so the dispatch outputs are sampled on the falling edge two rising edges after the stimulus was driven. `iss_ready` follows the freeing or flushing edge directly and is sampled one falling edge later. When several stations wake on the same broadcast, the bench samples one falling edge apart and expects their destination tags in station order. Checks that nothing dispatches look over two such sample points after the stimulus.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int RS_DATA_W = 16;
  parameter int RS_TAG_W  = 3;
  parameter int RS_OP_W   = 4;

  typedef logic [RS_DATA_W-1:0] data_t;
  typedef logic [RS_TAG_W-1:0]  rob_tag_t;
  typedef logic [RS_OP_W-1:0]   op_t;

  typedef struct packed {
    rob_tag_t tag;
    data_t    val;
  } src_t;

  typedef struct packed {
    op_t      op;
    rob_tag_t dst;
    src_t     s1;
    src_t     s2;
  } slot_t;

  // Settle one source operand at issue, including same-cycle broadcast bypass.
  function automatic src_t settle_src(input logic busy, input data_t rf_val,
                                      input rob_tag_t tag, input logic prod_rdy,
                                      input data_t prod_val, input logic bc_v,
                                      input rob_tag_t bc_t, input data_t bc_d);
    src_t r;
    r.tag = '0;
    r.val = rf_val;
    if (busy) begin
      if (prod_rdy) begin
        r.val = prod_val;
      end else if (bc_v && bc_t == tag) begin
        r.val = bc_d;
      end else begin
        r.tag = tag;
        r.val = '0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
    if (any) gnt[idx] = 1'b1;
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     alloc,
  input  slot_t    alloc_ent,
  input  logic     bc_valid,
  input  rob_tag_t bc_tag,
  input  data_t    bc_val,
  input  logic     fire,
  output logic     busy,
  output logic     ready,
  output slot_t    ent
);
  logic  busy_q, fired_q;
  slot_t ent_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy_q  <= 1'b0;
      fired_q <= 1'b0;
      ent_q   <= '0;
    end else if (alloc) begin
      busy_q  <= 1'b1;
      fired_q <= 1'b0;
      ent_q   <= alloc_ent;
    end else if (busy_q) begin
      if (bc_valid && ent_q.s1.tag != '0 && ent_q.s1.tag == bc_tag) begin
        ent_q.s1.val <= bc_val;
        ent_q.s1.tag <= '0;
      end
      if (bc_valid && ent_q.s2.tag != '0 && ent_q.s2.tag == bc_tag) begin
        ent_q.s2.val <= bc_val;
        ent_q.s2.tag <= '0;
      end
      if (fire) fired_q <= 1'b1;
      if (fired_q && bc_valid && bc_tag == ent_q.dst) busy_q <= 1'b0;
    end
  end

  assign busy  = busy_q;
  assign ready = busy_q && !fired_q && ent_q.s1.tag == '0 && ent_q.s2.tag == '0;
  assign ent   = ent_q;
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int N_RS = 4,
  localparam int IDX_W = (N_RS > 1) ? $clog2(N_RS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 iss_valid,
  input  logic [RS_OP_W-1:0]   iss_op,
  input  logic [RS_TAG_W-1:0]  iss_dst,
  input  logic                 a_busy,
  input  logic [RS_DATA_W-1:0] a_rf_val,
  input  logic [RS_TAG_W-1:0]  a_tag,
  input  logic                 a_prod_rdy,
  input  logic [RS_DATA_W-1:0] a_prod_val,
  input  logic                 b_busy,
  input  logic [RS_DATA_W-1:0] b_rf_val,
  input  logic [RS_TAG_W-1:0]  b_tag,
  input  logic                 b_prod_rdy,
  input  logic [RS_DATA_W-1:0] b_prod_val,
  output logic                 iss_ready,
  input  logic                 bc_valid,
  input  logic [RS_TAG_W-1:0]  bc_tag,
  input  logic [RS_DATA_W-1:0] bc_val,
  output logic                 disp_valid,
  output logic [RS_OP_W-1:0]   disp_op,
  output logic [RS_TAG_W-1:0]  disp_dst,
  output logic [RS_DATA_W-1:0] disp_a,
  output logic [RS_DATA_W-1:0] disp_b
);
  logic [N_RS-1:0]  busy_vec, ready_vec, alloc_gnt, fire_gnt, alloc_vec, fire_vec;
  logic [IDX_W-1:0] alloc_idx, fire_idx;
  logic             free_any, fire_any;
  slot_t            new_ent;
  slot_t            slot_q [N_RS];

  // Operands are settled once here and shared by all stations.
  always_comb begin
    new_ent.op  = iss_op;
    new_ent.dst = iss_dst;
    new_ent.s1  = settle_src(a_busy, a_rf_val, a_tag, a_prod_rdy, a_prod_val,
                             bc_valid, bc_tag, bc_val);
    new_ent.s2  = settle_src(b_busy, b_rf_val, b_tag, b_prod_rdy, b_prod_val,
                             bc_valid, bc_tag, bc_val);
  end

  rs_pick #(.N(N_RS)) u_alloc_pick (
    .req(~busy_vec), .gnt(alloc_gnt), .idx(alloc_idx), .any(free_any)
  );

  rs_pick #(.N(N_RS)) u_fire_pick (
    .req(ready_vec), .gnt(fire_gnt), .idx(fire_idx), .any(fire_any)
  );

  assign iss_ready = free_any;
  assign alloc_vec = alloc_gnt & {N_RS{iss_valid && !flush}};
  assign fire_vec  = fire_gnt & {N_RS{!flush}};

  for (genvar g = 0; g < N_RS; g++) begin : g_slot
    rs_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .alloc    (alloc_vec[g]),
      .alloc_ent(new_ent),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_val   (bc_val),
      .fire     (fire_vec[g]),
      .busy     (busy_vec[g]),
      .ready    (ready_vec[g]),
      .ent      (slot_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      disp_valid <= 1'b0;
      disp_op    <= '0;
      disp_dst   <= '0;
      disp_a     <= '0;
      disp_b     <= '0;
    end else begin
      disp_valid <= fire_any;
      if (fire_any) begin
        disp_op  <= slot_q[fire_idx].op;
        disp_dst <= slot_q[fire_idx].dst;
        disp_a   <= slot_q[fire_idx].s1.val;
        disp_b   <= slot_q[fire_idx].s2.val;
      end
    end
  end
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int N_RS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic [N_RS-1:0] busy_vec,
  input logic [N_RS-1:0] fire_vec,
  input logic            bc_valid,
  input logic            disp_valid
);
  p_one_fire_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fire_vec));

  p_fire_to_disp_r5: assert property (@(posedge clk) disable iff (rst)
    ((|fire_vec) && !flush) |=> disp_valid);

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (busy_vec == '0 && !disp_valid));

  for (genvar g = 0; g < N_RS; g++) begin : g_free
    p_free_by_bcast_r7: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy_vec[g]) && !$past(flush)) |-> $past(bc_valid));
  end
endmodule

bind rs_array rs_array_chk #(.N_RS(N_RS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .busy_vec  (busy_vec),
  .fire_vec  (fire_vec),
  .bc_valid  (bc_valid),
  .disp_valid(disp_valid)
);

// File: tb/rs_array_test.sv
`timescale 1ns/1ps
module rs_array_test;
  import rs_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic iss_valid = 1'b0;
  logic [RS_OP_W-1:0] iss_op = '0;
  logic [RS_TAG_W-1:0] iss_dst = '0;
  logic a_busy = 1'b0, a_prod_rdy = 1'b0, b_busy = 1'b0, b_prod_rdy = 1'b0;
  logic [RS_DATA_W-1:0] a_rf_val = '0, a_prod_val = '0, b_rf_val = '0, b_prod_val = '0;
  logic [RS_TAG_W-1:0] a_tag = '0, b_tag = '0;
  logic iss_ready;
  logic bc_valid = 1'b0;
  logic [RS_TAG_W-1:0] bc_tag = '0;
  logic [RS_DATA_W-1:0] bc_val = '0;
  logic disp_valid;
  logic [RS_OP_W-1:0] disp_op;
  logic [RS_TAG_W-1:0] disp_dst;
  logic [RS_DATA_W-1:0] disp_a, disp_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rs_array uut (
    .clk(clk), .rst(rst), .flush(flush),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
    .a_busy(a_busy), .a_rf_val(a_rf_val), .a_tag(a_tag),
    .a_prod_rdy(a_prod_rdy), .a_prod_val(a_prod_val),
    .b_busy(b_busy), .b_rf_val(b_rf_val), .b_tag(b_tag),
    .b_prod_rdy(b_prod_rdy), .b_prod_val(b_prod_val),
    .iss_ready(iss_ready),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
    .disp_a(disp_a), .disp_b(disp_b)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_disp(input string req, input logic [RS_OP_W-1:0] op,
                          input logic [RS_TAG_W-1:0] dst,
                          input logic [RS_DATA_W-1:0] va, input logic [RS_DATA_W-1:0] vb);
    chk({req, " valid"}, 32'(disp_valid), 32'd1);
    chk({req, " op"}, 32'(disp_op), 32'(op));
    chk({req, " dst"}, 32'(disp_dst), 32'(dst));
    chk({req, " a"}, 32'(disp_a), 32'(va));
    chk({req, " b"}, 32'(disp_b), 32'(vb));
  endtask

  // Present one issue for one edge; returns at the falling edge after capture.
  task automatic do_issue(input logic [RS_OP_W-1:0] op, input logic [RS_TAG_W-1:0] dst,
                          input logic ab, input logic [RS_DATA_W-1:0] arv,
                          input logic [RS_TAG_W-1:0] at, input logic ar,
                          input logic [RS_DATA_W-1:0] apv,
                          input logic bb, input logic [RS_DATA_W-1:0] brv,
                          input logic [RS_TAG_W-1:0] bt, input logic br,
                          input logic [RS_DATA_W-1:0] bpv);
    iss_valid = 1'b1; iss_op = op; iss_dst = dst;
    a_busy = ab; a_rf_val = arv; a_tag = at; a_prod_rdy = ar; a_prod_val = apv;
    b_busy = bb; b_rf_val = brv; b_tag = bt; b_prod_rdy = br; b_prod_val = bpv;
    tick();
    iss_valid = 1'b0; a_busy = 1'b0; b_busy = 1'b0;
  endtask

  task automatic do_bcast(input logic [RS_TAG_W-1:0] t, input logic [RS_DATA_W-1:0] v);
    bc_valid = 1'b1; bc_tag = t; bc_val = v;
    tick();
    bc_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset iss_ready", 32'(iss_ready), 32'd1);
    chk("R5 reset disp_valid", 32'(disp_valid), 32'd0);
  endtask

  task automatic t_plain_regs();
    // busy low with a nonzero tag: the tag must be ignored (R2)
    do_issue(4'h3, 3'd1, 1'b0, 16'h0011, 3'd7, 1'b0, 16'h0,
                         1'b0, 16'h0022, 3'd6, 1'b0, 16'h0);
    tick();
    chk_disp("R2 R5 plain", 4'h3, 3'd1, 16'h0011, 16'h0022);
    tick();
    chk("R5 single dispatch", 32'(disp_valid), 32'd0);
    do_bcast(3'd1, 16'h0);
  endtask

  task automatic t_wait_wake();
    do_issue(4'h5, 3'd2, 1'b1, 16'hdead, 3'd4, 1'b1, 16'h0033,
                         1'b1, 16'hbeef, 3'd5, 1'b0, 16'h0);
    tick();
    chk("R4 waits", 32'(disp_valid), 32'd0);
    tick();
    chk("R4 still waits", 32'(disp_valid), 32'd0);
    do_bcast(3'd5, 16'h0044);
    tick();
    chk_disp("R3 R6 wake", 4'h5, 3'd2, 16'h0033, 16'h0044);
    do_bcast(3'd2, 16'h0);
  endtask

  task automatic t_bypass();
    bc_valid = 1'b1; bc_tag = 3'd6; bc_val = 16'h0055;
    do_issue(4'h7, 3'd3, 1'b1, 16'h0, 3'd6, 1'b0, 16'h0,
                         1'b0, 16'h0066, 3'd0, 1'b0, 16'h0);
    bc_valid = 1'b0;
    tick();
    chk_disp("R9 bypass", 4'h7, 3'd3, 16'h0055, 16'h0066);
    do_bcast(3'd3, 16'h0);
  endtask

  task automatic t_priority_full();
    do_issue(4'h1, 3'd1, 1'b1, 16'h0, 3'd7, 1'b0, 16'h0, 1'b0, 16'h0101, 3'd0, 1'b0, 16'h0);
    do_issue(4'h2, 3'd2, 1'b0, 16'h0202, 3'd0, 1'b0, 16'h0, 1'b1, 16'h0, 3'd7, 1'b0, 16'h0);
    do_issue(4'h3, 3'd3, 1'b1, 16'h0, 3'd7, 1'b0, 16'h0, 1'b0, 16'h0303, 3'd0, 1'b0, 16'h0);
    do_bcast(3'd7, 16'h0077);
    tick();
    chk_disp("R8 first", 4'h1, 3'd1, 16'h0077, 16'h0101);
    tick();
    chk_disp("R8 R6 second src", 4'h2, 3'd2, 16'h0202, 16'h0077);
    tick();
    chk_disp("R8 third", 4'h3, 3'd3, 16'h0077, 16'h0303);
    do_issue(4'h4, 3'd4, 1'b1, 16'h0, 3'd6, 1'b0, 16'h0, 1'b0, 16'h0404, 3'd0, 1'b0, 16'h0);
    chk("R1 full", 32'(iss_ready), 32'd0);
    do_issue(4'h9, 3'd5, 1'b0, 16'h0909, 3'd0, 1'b0, 16'h0, 1'b0, 16'h0909, 3'd0, 1'b0, 16'h0);
    chk("R1 stalled issue", 32'(disp_valid), 32'd0);
    tick();
    chk("R1 stalled issue later", 32'(disp_valid), 32'd0);
    do_bcast(3'd2, 16'h0);
    chk("R7 freed", 32'(iss_ready), 32'd1);
    do_issue(4'h6, 3'd5, 1'b0, 16'h0606, 3'd0, 1'b0, 16'h0, 1'b0, 16'h0660, 3'd0, 1'b0, 16'h0);
    chk("R7 R8 refilled full", 32'(iss_ready), 32'd0);
    tick();
    chk_disp("R7 reuse", 4'h6, 3'd5, 16'h0606, 16'h0660);
  endtask

  task automatic t_flush();
    flush = 1'b1;
    tick();
    flush = 1'b0;
    chk("R10 ready after flush", 32'(iss_ready), 32'd1);
    chk("R10 disp cleared", 32'(disp_valid), 32'd0);
    do_bcast(3'd6, 16'h0abc);
    chk("R10 no stale wake", 32'(disp_valid), 32'd0);
    tick();
    chk("R10 no stale wake later", 32'(disp_valid), 32'd0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_plain_regs();
    t_wait_wake();
    t_bypass();
    t_priority_full();
    t_flush();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule